// File: doc/BRIEF.md
# Five-State Non-Binary Sequence Counter

This block is a synchronous counter whose 3-bit registered state steps through a fixed loop of five codes: 3, 1, 4, 7, 2, then back to 3. The register contents drive the `count` output directly, with no output decoding. The next state comes from minimised sum-of-products logic over the three current state bits. A count enable gates each step.

The three codes outside the loop are 0, 5 and 6. Each of them leads back to code 3 on the next enabled edge, so the counter corrects itself after an upset. Reset is asserted asynchronously and active-low, and an internal synchroniser releases it. The reset code is a parameter. It defaults to 3. It can be set to an unused code so that recovery can be observed at the ports.

Top module: `arb_seq_counter`

## Requirements
- R1: While `rst_n` is low, `count` shows the reset code without waiting for a clock edge. With the default parameter that code is 3.
- R2: On an enabled rising edge, code 3 becomes code 1.
- R3: On an enabled rising edge, code 1 becomes code 4 and code 4 becomes code 7.
- R4: On an enabled rising edge, code 7 becomes code 2 and code 2 becomes code 3, which closes the five-code loop.
- R5: When `en` is low at a rising edge, `count` keeps its value. This applies to loop codes and to unused codes.
- R6: On an enabled rising edge, the unused codes 0, 5 and 6 each become code 3. The counter then continues in the loop (3 then 1).
- R7: After `rst_n` rises, the first SYNC_STAGES rising edges (default 2) leave the reset code unchanged even if `en` is high. The edge after those counts.
- R8: The parameter RESET_CODE sets the value that reset loads. The 3-bit `count` equals the stored state code directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset: asserted asynchronously, released synchronously |
| en | input | 1 | Count enable; the state steps only on edges where it is high |
| count | output | 3 | Current state code, unsigned binary |

## Verification
Two events can meet on the same edge: the release of the internal reset and a count step requested by `en`. The bench provokes this by raising `rst_n` while `en` is already high. It then checks after each edge that the count stays at the reset code through the synchroniser stages and only then moves to 1. A second reset is asserted halfway between edges, and the bench checks that `count` goes back to 3 at once.

// File: rtl/cnt_seq_pkg.sv
package cnt_seq_pkg;
  localparam int CW = 3;
  typedef logic [CW-1:0] code_t;

  localparam code_t HOME_CODE = 3'd3;

  // Golden successor table, used only by checks.
  function automatic code_t seq_succ(code_t c);
    case (c)
      3'd3:    return 3'd1;
      3'd1:    return 3'd4;
      3'd4:    return 3'd7;
      3'd7:    return 3'd2;
      3'd2:    return 3'd3;
      default: return HOME_CODE;
    endcase
  endfunction

  function automatic logic in_loop(code_t c);
    return (c == 3'd3) || (c == 3'd1) || (c == 3'd4) ||
           (c == 3'd7) || (c == 3'd2);
  endfunction
endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cnt_next_logic.sv
module cnt_next_logic
  import cnt_seq_pkg::*;
(
  input  code_t q,
  input  logic  en,
  output code_t d
);
  code_t sop;

  always_comb begin
    // bit 2: set from 1 (001) and 4 (100)
    sop[2] = (~q[2] & ~q[1] &  q[0]) | (q[2] & ~q[1] & ~q[0]);
    // bit 1: clear only for 1 and 3
    sop[1] = q[2] | ~q[0];
    // bit 0: clear only for 1 and 7
    sop[0] = ~q[0] | (q[2] & ~q[1]) | (~q[2] & q[1]);
  end

  always_comb begin
    if (en) begin
      d = sop;
    end else begin
      d = q;
    end
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_seq_pkg::*;
#(
  parameter code_t RESET_CODE = HOME_CODE
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t d,
  output code_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_CODE;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/arb_seq_counter.sv
module arb_seq_counter
  import cnt_seq_pkg::*;
#(
  parameter code_t RESET_CODE  = HOME_CODE,
  parameter int    SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic [2:0] count
);
  logic  rst_int_n;
  code_t state_q;
  code_t state_d;

  cnt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cnt_next_logic u_next (
    .q  (state_q),
    .en (en),
    .d  (state_d)
  );

  cnt_state_reg #(.RESET_CODE(RESET_CODE)) u_reg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (state_d),
    .q     (state_q)
  );

  assign count = state_q;

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && in_loop(state_q)) |=> (state_q == seq_succ($past(state_q))));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> $stable(state_q));

  // R6
  recover_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && !in_loop(state_q)) |=> (state_q == HOME_CODE));

  // R4
  legal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    en |=> in_loop(state_q));
endmodule

// File: tb/sim_arb_seq_counter.sv
module sim_arb_seq_counter;
  localparam time PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       en_r;
  logic [2:0] count, cnt0, cnt5, cnt6;
  int         n_run  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  always #(PERIOD/2) clk = ~clk;

  arb_seq_counter u0 (.clk(clk), .rst_n(rst_n), .en(en), .count(count));
  arb_seq_counter #(.RESET_CODE(3'd0)) u_r0 (.clk(clk), .rst_n(rst_n), .en(en_r), .count(cnt0));
  arb_seq_counter #(.RESET_CODE(3'd5)) u_r5 (.clk(clk), .rst_n(rst_n), .en(en_r), .count(cnt5));
  arb_seq_counter #(.RESET_CODE(3'd6)) u_r6 (.clk(clk), .rst_n(rst_n), .en(en_r), .count(cnt6));

  // {en, expected count after the edge}; two laps with holds inserted
  localparam logic [3:0] VEC [12] = '{
    {1'b1,3'd1}, {1'b1,3'd4}, {1'b0,3'd4}, {1'b1,3'd7},
    {1'b1,3'd2}, {1'b1,3'd3}, {1'b1,3'd1}, {1'b1,3'd4},
    {1'b1,3'd7}, {1'b0,3'd7}, {1'b1,3'd2}, {1'b1,3'd3}
  };

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: count=%0d expected=done", count);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b1;
    en_r  = 1'b0;
    #(PERIOD * 3 + 1);
    check(count, 3'd3, "R1 reset value");
    check(cnt5, 3'd5, "R8 reset code parameter");

    // release with enable already high: R7
    @(negedge clk);
    rst_n = 1'b1;
    edge_then_sample();
    check(count, 3'd3, "R7 first edge after release");
    edge_then_sample();
    check(count, 3'd3, "R7 second edge after release");
    edge_then_sample();
    check(count, 3'd1, "R7 first counting edge");

    // asynchronous reset mid-cycle: R1
    #(PERIOD/4);
    rst_n = 1'b0;
    #1;
    check(count, 3'd3, "R1 async assert");
    @(negedge clk);
    en    = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      en = VEC[i][3];
      edge_then_sample();
      check(count, VEC[i][2:0], "R2/R3/R4/R5 sequence");
    end

    // recovery from unused codes: R6, R5
    @(negedge clk);
    en = 1'b0;
    en_r = 1'b0;
    edge_then_sample();
    check(cnt0, 3'd0, "R5 hold unused 0");
    check(cnt5, 3'd5, "R5 hold unused 5");
    check(cnt6, 3'd6, "R5 hold unused 6");
    @(negedge clk);
    en_r = 1'b1;
    edge_then_sample();
    check(cnt0, 3'd3, "R6 recover from 0");
    check(cnt5, 3'd3, "R6 recover from 5");
    check(cnt6, 3'd3, "R6 recover from 6");
    edge_then_sample();
    check(cnt0, 3'd1, "R6 continue after recovery 0");
    check(cnt5, 3'd1, "R6 continue after recovery 5");
    check(cnt6, 3'd1, "R6 continue after recovery 6");
    check(count, 3'd3, "R5 main held while its enable low");

    finish_run();
  end
endmodule